// File: doc/BRIEF.md
# Configurable Output Cell for a Sum-of-Products Logic Array

This block is a single output cell of a small programmable sum-of-products device. It takes the OR-sum that the array produces for this cell and routes it to a pad. The path runs either straight through or through a flip-flop clocked by the global clock. A polarity stage follows that choice, so the pin carries the selected value either as it is or inverted. Two global array terms act on the flip-flop: an asynchronous clear and a synchronous set. Because polarity is applied after the flip-flop, these terms fix the stored state, and the pin level then depends on the polarity setting.

The cell drives a three-state pad model through an enable, which comes from its own product term, and a data value. It also receives the level actually present on the pin. A feedback signal goes back to the array. In registered mode it carries the stored state. In combinational mode it carries the pin level, so a cell whose enable is held off acts as a plain input. For test, a preload mode captures the pin level into the flip-flop on a clock edge, which lets a tester reach any state. A security flag blocks this preload.

The flip-flop powers up cleared. The asynchronous clear term serves as the power-up and system reset input.

Top module: `pl_outcell`

## Requirements
- R1: With `cfg_pol` = 1 (active high), `pad_out` equals the selected value: the stored bit in registered mode, `sum_in` in combinational mode.
- R2: With `cfg_pol` = 0, `pad_out` is the inverse of the selected value in both registered and combinational mode.
- R3: With `cfg_reg` = 1, the stored bit takes `sum_in` on a rising `clk` edge when neither preset nor an allowed preload is active. With `cfg_reg` = 0, `pad_out` follows `sum_in` with no clock.
- R4: While `arst_term` is high, the stored bit is 0 at once, without any clock edge. In registered mode the pin then shows 0 when `cfg_pol` = 1 and 1 when `cfg_pol` = 0. This also holds at start-up.
- R5: When `spre_term` is high at a rising edge and no allowed preload is active, the stored bit becomes 1, whatever `sum_in` is.
- R6: `arst_term` wins over `spre_term`. With both high across an edge, the stored bit stays 0.
- R7: `pad_oe` equals `oe_term`. When it is 0 the pin is released and carries whatever an external source drives.
- R8: `fb_out` equals the stored bit when `cfg_reg` = 1 and equals `pad_in` when `cfg_reg` = 0.
- R9: When `pl_en` = 1 and `secure` = 0 at a rising edge, the stored bit takes the `pad_in` level sampled at that edge. This wins over preset and `sum_in`.
- R10: When `secure` = 1, `pl_en` has no effect. The stored bit follows R5 and R3 as if `pl_en` were 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global clock; rising edge active |
| arst_term | input | 1 | Asynchronous clear term, active high; also the power-up reset |
| spre_term | input | 1 | Synchronous preset term, active high |
| sum_in | input | 1 | OR-sum of this cell's product terms |
| oe_term | input | 1 | Output-enable product term |
| cfg_reg | input | 1 | 1 = registered, 0 = combinational |
| cfg_pol | input | 1 | 1 = active high, 0 = inverted output |
| pl_en | input | 1 | Test preload request |
| secure | input | 1 | Security flag; blocks preload when 1 |
| pad_in | input | 1 | Level present on the pin |
| pad_oe | output | 1 | Three-state enable for the pad driver |
| pad_out | output | 1 | Data value for the pad driver |
| fb_out | output | 1 | Feedback to the array |

## Verification
The main path is exercised in all four combinations of mode and polarity, with `sum_in` toggling. This separates a missing inversion from a mode mixup: in registered mode the pin moves only after an edge, and in combinational mode it moves at once. Feedback is tried with the pad enabled and disabled while an external level opposes the cell's own output. That shows whether the feedback source is the register or the pin. Preload is run against opposing `sum_in` and preset values, with and without the security flag, and once with the pad enabled, where the pin carries the cell's own output. The clear/preset collision and a mid-cycle clear show both the priority order and the absence of any clock dependence.

// File: rtl/pl_outcell_pkg.sv
package pl_outcell_pkg;

    // Source the flip-flop takes at the next rising edge
    typedef enum logic [1:0] {
        LD_SUM    = 2'd0,
        LD_PRESET = 2'd1,
        LD_PIN    = 2'd2
    } load_src_e;

    // Registered state of one cell
    typedef struct packed {
        logic bit_v;
    } cell_state_t;

    // Combinational view of one cell's pad side
    typedef struct packed {
        logic core;
        logic drv;
        logic oe;
        logic fb;
    } pad_view_t;

endpackage

// File: rtl/pl_outcell_ff.sv
module pl_outcell_ff
    import pl_outcell_pkg::*;
(
    input  logic clk,
    input  logic arst_term,
    input  logic spre_term,
    input  logic sum_in,
    input  logic pl_en,
    input  logic secure,
    input  logic pad_in,
    output logic bit_q
);

    cell_state_t st_d;
    cell_state_t st_q;
    load_src_e   src_d;
    logic        pl_ok_d;

    always_comb begin
        pl_ok_d = pl_en && !secure;
        if (pl_ok_d) begin
            src_d = LD_PIN;
        end else if (spre_term) begin
            src_d = LD_PRESET;
        end else begin
            src_d = LD_SUM;
        end
        st_d = st_q;
        unique case (src_d)
            LD_PIN:    st_d.bit_v = pad_in;
            LD_PRESET: st_d.bit_v = 1'b1;
            default:   st_d.bit_v = sum_in;
        endcase
    end

    always_ff @(posedge clk or posedge arst_term) begin
        if (arst_term) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_q = st_q.bit_v;

    always @(posedge clk) begin
        if (arst_term) begin
            AST_ARST_CLEAR: assert (st_q.bit_v == 1'b0); // R4
        end
    end

    AST_PRESET_SETS: assert property (@(posedge clk) disable iff (arst_term)
        (spre_term && !(pl_en && !secure)) |=> st_q.bit_v); // R5

    AST_PRELOAD_PIN: assert property (@(posedge clk) disable iff (arst_term)
        (pl_en && !secure) |=> (st_q.bit_v == $past(pad_in))); // R9

    AST_SECURE_BLOCK: assert property (@(posedge clk) disable iff (arst_term)
        (pl_en && secure && !spre_term) |=> (st_q.bit_v == $past(sum_in))); // R10

    AST_DATA_LOAD: assert property (@(posedge clk) disable iff (arst_term)
        (!pl_en && !spre_term) |=> (st_q.bit_v == $past(sum_in))); // R3

endmodule

// File: rtl/pl_outcell_io.sv
module pl_outcell_io
    import pl_outcell_pkg::*;
(
    input  logic cfg_reg,
    input  logic cfg_pol,
    input  logic sum_in,
    input  logic bit_q,
    input  logic oe_term,
    input  logic pad_in,
    output logic pad_oe,
    output logic pad_out,
    output logic fb_out
);

    pad_view_t pv_d;

    always_comb begin
        pv_d.core = cfg_reg ? bit_q : sum_in;
        pv_d.drv  = cfg_pol ? pv_d.core : ~pv_d.core;
        pv_d.oe   = oe_term;
        pv_d.fb   = cfg_reg ? bit_q : pad_in;
    end

    assign pad_oe  = pv_d.oe;
    assign pad_out = pv_d.drv;
    assign fb_out  = pv_d.fb;

endmodule

// File: rtl/pl_outcell.sv
module pl_outcell
    import pl_outcell_pkg::*;
(
    input  logic clk,
    input  logic arst_term,
    input  logic spre_term,
    input  logic sum_in,
    input  logic oe_term,
    input  logic cfg_reg,
    input  logic cfg_pol,
    input  logic pl_en,
    input  logic secure,
    input  logic pad_in,
    output logic pad_oe,
    output logic pad_out,
    output logic fb_out
);

    logic bit_q;

    pl_outcell_ff u_ff (
        .clk       (clk),
        .arst_term (arst_term),
        .spre_term (spre_term),
        .sum_in    (sum_in),
        .pl_en     (pl_en),
        .secure    (secure),
        .pad_in    (pad_in),
        .bit_q     (bit_q)
    );

    pl_outcell_io u_io (
        .cfg_reg (cfg_reg),
        .cfg_pol (cfg_pol),
        .sum_in  (sum_in),
        .bit_q   (bit_q),
        .oe_term (oe_term),
        .pad_in  (pad_in),
        .pad_oe  (pad_oe),
        .pad_out (pad_out),
        .fb_out  (fb_out)
    );

endmodule

// File: tb/sim_pl_outcell.sv
module sim_pl_outcell;

    logic clk = 1'b0;
    logic arst_term, spre_term, sum_in, oe_term, cfg_reg, cfg_pol;
    logic pl_en, secure, ext_lvl;
    logic pad_in, pad_oe, pad_out, fb_out;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;
    logic model_q;

    always #4 clk = ~clk;

    // Pin model: the cell's driver when enabled, otherwise the external level
    assign pad_in = pad_oe ? pad_out : ext_lvl;

    pl_outcell u0 (
        .clk(clk), .arst_term(arst_term), .spre_term(spre_term), .sum_in(sum_in),
        .oe_term(oe_term), .cfg_reg(cfg_reg), .cfg_pol(cfg_pol), .pl_en(pl_en),
        .secure(secure), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .fb_out(fb_out)
    );

    // Vector fields: {cfg_reg, cfg_pol, sum, spre, pl_en, secure, ext, oe}
    localparam logic [7:0] VEC [16] = '{
        8'b1110_0001, 8'b1100_0001, 8'b1010_0001, 8'b1001_0001,
        8'b1101_0000, 8'b1110_0000, 8'b0110_0001, 8'b0010_0001,
        8'b0100_0010, 8'b0000_0000, 8'b1100_1010, 8'b1110_1000,
        8'b1101_1000, 8'b1100_1110, 8'b1110_1100, 8'b1000_1011
    };

    function automatic logic exp_out(input logic q);
        logic core;
        core = cfg_reg ? q : sum_in;
        return cfg_pol ? core : ~core;
    endfunction

    function automatic logic exp_pin(input logic q);
        return oe_term ? exp_out(q) : ext_lvl;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic [7:0] v);
        logic pin_at_edge;
        @(negedge clk);
        {cfg_reg, cfg_pol, sum_in, spre_term, pl_en, secure, ext_lvl, oe_term} = v;
        pin_at_edge = exp_pin(model_q);
        @(posedge clk);
        if (pl_en && !secure)  model_q = pin_at_edge;
        else if (spre_term)    model_q = 1'b1;
        else                   model_q = sum_in;
        #2;
        chk("R1 R2 R3 R5 R9 R10 pad_out", pad_out, exp_out(model_q));
        chk("R8 fb_out", fb_out, cfg_reg ? model_q : exp_pin(model_q));
        chk("R7 pad_oe", pad_oe, oe_term);
    endtask

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        arst_term = 1'b1; spre_term = 1'b0; sum_in = 1'b1; oe_term = 1'b1;
        cfg_reg = 1'b1; cfg_pol = 1'b1; pl_en = 1'b0; secure = 1'b0; ext_lvl = 1'b0;
        model_q = 1'b0;
        repeat (2) @(negedge clk);
        // R4 reset state, active high then inverted
        chk("R4 reset pad_out high-pol", pad_out, 1'b0);
        chk("R4 reset fb_out", fb_out, 1'b0);
        cfg_pol = 1'b0;
        #1;
        chk("R4 reset pad_out low-pol", pad_out, 1'b1);
        @(negedge clk);
        arst_term = 1'b0; sum_in = 1'b0; cfg_pol = 1'b1;

        for (int i = 0; i < 16; i++) step(VEC[i]);

        // R6: clear and preset together across an edge
        @(negedge clk);
        cfg_reg = 1'b1; cfg_pol = 1'b1; pl_en = 1'b0; secure = 1'b0;
        spre_term = 1'b1; arst_term = 1'b1;
        @(posedge clk); #2;
        chk("R6 clear beats preset", fb_out, 1'b0);
        @(negedge clk);
        arst_term = 1'b0;
        @(posedge clk); #2;
        chk("R5 preset after release", fb_out, 1'b1);

        // R4: mid-cycle clear with no edge in between
        @(negedge clk);
        spre_term = 1'b0; sum_in = 1'b1; cfg_pol = 1'b0;
        @(posedge clk); #2;
        chk("R2 registered inverted", pad_out, 1'b0);
        #1;
        arst_term = 1'b1;
        #1;
        chk("R4 async clear fb_out", fb_out, 1'b0);
        chk("R4 async clear pad_out", pad_out, 1'b1);
        @(negedge clk);
        arst_term = 1'b0;
        model_q = 1'b0;

        // R8/R7: dedicated input use, enable off, external level read back
        @(negedge clk);
        cfg_reg = 1'b0; cfg_pol = 1'b1; oe_term = 1'b0; sum_in = 1'b0; ext_lvl = 1'b1;
        #1;
        chk("R7 pad released", pad_oe, 1'b0);
        chk("R8 input readback high", fb_out, 1'b1);
        ext_lvl = 1'b0;
        #1;
        chk("R8 input readback low", fb_out, 1'b0);

        // R10: secure blocks preload of an opposing pin level
        @(negedge clk);
        cfg_reg = 1'b1; sum_in = 1'b0; pl_en = 1'b1; secure = 1'b1; ext_lvl = 1'b1;
        @(posedge clk); #2;
        chk("R10 preload blocked", fb_out, 1'b0);
        @(negedge clk);
        secure = 1'b0;
        @(posedge clk); #2;
        chk("R9 preload taken", fb_out, 1'b1);
        @(negedge clk);
        pl_en = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule